// File: doc/BRIEF.md
# Peripheral Access Violation Monitor

This block sits beside the register bus of a cryptographic peripheral and watches every software access and every start command. It decides whether an access breaks the write-protect policy or counts as a software misuse, and it records the result in one 32-bit read-only status word. Sticky flags also collect three external fault indications: a sequencer fault, a clock glitch and a private-key access fault. Reading the status word through the same bus clears it.

Software misuse is sorted by type and tagged as a warning or an error. The offending register index goes into an address field. A write-protect violation owns that field as soon as one is recorded.

Two small state machines hold the records. The software-error machine has the states `SWE_IDLE`, `SWE_WARN` and `SWE_ERR`:
- `take_warn` moves it from idle to warn.
- `take_err` moves it from idle or warn to err.
- `clear` sends any state back to idle.

The write-protect machine has the states `WP_OPEN` and `WP_LATCHED`:
- `latch` moves it from open to latched on the first protected write.
- `clear` moves it back to open.

Top module: `access_violation_monitor`

## Requirements
- R1: After reset, and after a clearing read with no event in the same cycle, the status word is zero. Bits 30:28, 23:16 and 7:5 always read zero. The field layout is:
  - bit 0: write-protect violation
  - bit 1: clock glitch
  - bit 2: sequencer fault
  - bit 3: software error
  - bit 4: private-key fault
  - bits 15:8: register index (byte offset shifted right by 2)
  - bits 27:24: error type
  - bit 31: class (1 = error)
- R2: The protected registers are index 1 (configuration) and indices 4 to 11 (key). A write to one of them while `wp_enable` is 1 sets bit 0 and stores that index in bits 15:8. Such a write is not also counted as a software error.
- R3: While bit 0 is set, bits 15:8 keep the index of the first protected write. Later protect violations and later software errors do not change them.
- R4: The following bus misuse records a warning (class 0) with the access's index in bits 15:8 while bit 0 is clear:
  - A read of a write-only register (index 0 control, indices 4 to 15 key and input data) gives type 0.
  - A write to a read-only register (index 2, indices 16 to 19 output) gives type 1.
  - Any access to an undefined index gives type 2.
- R5: While `busy` is 1, the following accesses record type 4:
  - A write to key, input or control registers gives class 1.
  - A write to the configuration register or a read of the output registers gives class 0.
- R6: A `start_cmd` pulse with `dma_mode` 1 records type 3, class 0. Otherwise, a `start_cmd` pulse with `key_loaded` 0 records type 5, class 1. Both record index 0. In a cycle with both a start error and a bus error, the start error is the one offered.
- R7: With several software errors before a read, the first record (type, class, index) is kept. The one exception: a class-1 event replaces a held class-0 record.
- R8: Bits 1, 2 and 4 are set only by `clk_glitch`, `seq_fault` and `pkey_fault` respectively. Each stays set until a clearing read.
- R9: A read of index 58 (byte offset 0xE8) clears the whole word at the next edge. The read cycle still shows the old value. An event in the same cycle as the clearing read is left recorded afterwards.
- R10: A read or write of index 58 never records a violation or a software error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte offset of the current access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| wp_enable | input | 1 | Write protection enabled |
| busy | input | 1 | Cipher processing in progress |
| key_loaded | input | 1 | Key registers fully written |
| dma_mode | input | 1 | DMA-driven operation configured |
| start_cmd | input | 1 | Software start command pulse |
| seq_fault | input | 1 | Internal sequencer fault pulse |
| clk_glitch | input | 1 | Clock monitor glitch pulse |
| pkey_fault | input | 1 | Private-key register access fault pulse |
| status_word | output | 32 | Sticky status word |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high together. They also assume that a clearing read is not combined with a write. The bench respects this:
- Directed accesses drive exactly one strobe.
- The randomized phase picks a single access kind per cycle.

The reference model clears first and then applies the cycle's events. This matches the rule that an event wins over a clearing read, and dedicated cycles combine a status read with fault pulses and start commands to exercise it.

// File: rtl/avm_pkg.sv
package avm_pkg;

    localparam int unsigned STATUS_IDX = 58;

    typedef enum logic [2:0] {
        K_CTRL,
        K_CFG,
        K_STAT,
        K_KEY,
        K_DIN,
        K_DOUT,
        K_SELF,
        K_UNDEF
    } reg_kind_e;

    typedef enum logic [3:0] {
        SWT_READ_WO   = 4'd0,
        SWT_WRITE_RO  = 4'd1,
        SWT_UNDEF     = 4'd2,
        SWT_DMA_START = 4'd3,
        SWT_BUSY_ACC  = 4'd4,
        SWT_NO_KEY    = 4'd5
    } swe_type_e;

    typedef struct packed {
        logic       cls;
        logic [3:0] typ;
        logic [7:0] addr;
    } swe_rec_t;

    function automatic reg_kind_e kind_of(input int unsigned idx);
        if (idx == 0)                 return K_CTRL;
        if (idx == 1)                 return K_CFG;
        if (idx == 2)                 return K_STAT;
        if (idx >= 4 && idx <= 11)    return K_KEY;
        if (idx >= 12 && idx <= 15)   return K_DIN;
        if (idx >= 16 && idx <= 19)   return K_DOUT;
        if (idx == STATUS_IDX)        return K_SELF;
        return K_UNDEF;
    endfunction

endpackage

// File: rtl/avm_classifier.sv
module avm_classifier
    import avm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              wp_enable,
    input  logic              busy,
    input  logic              key_loaded,
    input  logic              dma_mode,
    input  logic              start_cmd,
    output logic              self_rd,
    output logic              wp_hit,
    output logic              swe_hit,
    output swe_rec_t          swe_ev,
    output logic [7:0]        acc_field
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic [IDX_W+7:0] idx_ext;
    reg_kind_e        kind;
    logic             acc_hit;
    logic             acc_cls;
    logic [3:0]       acc_typ;
    logic             st_hit;
    logic             st_cls;
    logic [3:0]       st_typ;
    logic             is_wo;
    logic             is_ro;

    assign idx       = bus_addr[ADDR_W-1:2];
    assign idx_ext   = {8'h00, idx};
    assign acc_field = idx_ext[7:0];
    assign kind      = kind_of(32'(idx));

    always_comb begin
        is_wo   = (kind == K_CTRL) || (kind == K_KEY) || (kind == K_DIN);
        is_ro   = (kind == K_STAT) || (kind == K_DOUT);
        self_rd = bus_rd && (kind == K_SELF);
        wp_hit  = bus_wr && wp_enable && ((kind == K_CFG) || (kind == K_KEY));

        acc_hit = 1'b0;
        acc_cls = 1'b0;
        acc_typ = SWT_READ_WO;
        if ((bus_rd || bus_wr) && (kind != K_SELF) && !wp_hit) begin
            if (kind == K_UNDEF) begin
                acc_hit = 1'b1;
                acc_typ = SWT_UNDEF;
            end else if (bus_rd && is_wo) begin
                acc_hit = 1'b1;
                acc_typ = SWT_READ_WO;
            end else if (bus_wr && is_ro) begin
                acc_hit = 1'b1;
                acc_typ = SWT_WRITE_RO;
            end else if (busy && bus_wr && is_wo) begin
                acc_hit = 1'b1;
                acc_typ = SWT_BUSY_ACC;
                acc_cls = 1'b1;
            end else if (busy && ((bus_wr && kind == K_CFG) ||
                                  (bus_rd && kind == K_DOUT))) begin
                acc_hit = 1'b1;
                acc_typ = SWT_BUSY_ACC;
            end
        end

        st_hit = 1'b0;
        st_cls = 1'b0;
        st_typ = SWT_DMA_START;
        if (start_cmd && dma_mode) begin
            st_hit = 1'b1;
        end else if (start_cmd && !key_loaded) begin
            st_hit = 1'b1;
            st_typ = SWT_NO_KEY;
            st_cls = 1'b1;
        end

        swe_hit = st_hit || acc_hit;
        if (st_hit) begin
            swe_ev = '{cls: st_cls, typ: st_typ, addr: 8'h00};
        end else begin
            swe_ev = '{cls: acc_cls, typ: acc_typ, addr: acc_field};
        end
    end

endmodule

// File: rtl/avm_swe_fsm.sv
module avm_swe_fsm
    import avm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  logic     hit,
    input  swe_rec_t ev,
    output logic     active,
    output swe_rec_t rec
);

    typedef enum logic [1:0] {
        SWE_IDLE,
        SWE_WARN,
        SWE_ERR
    } swe_state_e;

    swe_state_e st_q, st_d, base_st;
    swe_rec_t   rec_q, rec_d;
    logic       take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SWE_IDLE;
            rec_q <= '0;
        end else begin
            st_q  <= st_d;
            rec_q <= rec_d;
        end
    end

    always_comb begin
        base_st = clr ? SWE_IDLE : st_q;
        rec_d   = clr ? swe_rec_t'('0) : rec_q;
        unique case (base_st)
            SWE_IDLE: take = hit;
            SWE_WARN: take = hit && ev.cls;
            SWE_ERR:  take = 1'b0;
            default:  take = 1'b0;
        endcase
        st_d = base_st;
        if (take) begin
            st_d  = ev.cls ? SWE_ERR : SWE_WARN;
            rec_d = ev;
        end
    end

    always_comb begin
        active = (st_q != SWE_IDLE);
        rec    = rec_q;
    end

endmodule

// File: rtl/avm_wp_fsm.sv
module avm_wp_fsm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       hit,
    input  logic [7:0] hit_addr,
    output logic       active,
    output logic [7:0] addr
);

    typedef enum logic {
        WP_OPEN,
        WP_LATCHED
    } wp_state_e;

    wp_state_e  st_q, st_d, base_st;
    logic [7:0] addr_q, addr_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= WP_OPEN;
            addr_q <= 8'h00;
        end else begin
            st_q   <= st_d;
            addr_q <= addr_d;
        end
    end

    always_comb begin
        base_st = clr ? WP_OPEN : st_q;
        addr_d  = clr ? 8'h00 : addr_q;
        st_d    = base_st;
        unique case (base_st)
            WP_OPEN: begin
                if (hit) begin
                    st_d   = WP_LATCHED;
                    addr_d = hit_addr;
                end
            end
            WP_LATCHED: st_d = WP_LATCHED;
            default:    st_d = WP_OPEN;
        endcase
    end

    always_comb begin
        active = (st_q == WP_LATCHED);
        addr   = addr_q;
    end

endmodule

// File: rtl/access_violation_monitor.sv
module access_violation_monitor
    import avm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              wp_enable,
    input  logic              busy,
    input  logic              key_loaded,
    input  logic              dma_mode,
    input  logic              start_cmd,
    input  logic              seq_fault,
    input  logic              clk_glitch,
    input  logic              pkey_fault,
    output logic [31:0]       status_word
);

    localparam int N_FAULT = 3;

    logic       self_rd;
    logic       wp_hit;
    logic       swe_hit;
    swe_rec_t   swe_ev;
    logic [7:0] acc_field;
    logic       swe_active;
    swe_rec_t   swe_rec;
    logic       wp_active;
    logic [7:0] wp_addr;
    logic [7:0] addr_field;

    logic [N_FAULT-1:0] fault_in;
    logic [N_FAULT-1:0] fault_q;

    avm_classifier #(.ADDR_W(ADDR_W)) u_class (
        .bus_addr   (bus_addr),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .wp_enable  (wp_enable),
        .busy       (busy),
        .key_loaded (key_loaded),
        .dma_mode   (dma_mode),
        .start_cmd  (start_cmd),
        .self_rd    (self_rd),
        .wp_hit     (wp_hit),
        .swe_hit    (swe_hit),
        .swe_ev     (swe_ev),
        .acc_field  (acc_field)
    );

    avm_swe_fsm u_swe (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (self_rd),
        .hit    (swe_hit),
        .ev     (swe_ev),
        .active (swe_active),
        .rec    (swe_rec)
    );

    avm_wp_fsm u_wp (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (self_rd),
        .hit      (wp_hit),
        .hit_addr (acc_field),
        .active   (wp_active),
        .addr     (wp_addr)
    );

    assign fault_in = {pkey_fault, seq_fault, clk_glitch};

    for (genvar g = 0; g < N_FAULT; g++) begin : g_fault
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fault_q[g] <= 1'b0;
            end else begin
                fault_q[g] <= (fault_q[g] && !self_rd) || fault_in[g];
            end
        end
    end

    assign addr_field = wp_active ? wp_addr : swe_rec.addr;

    assign status_word = {swe_rec.cls, 3'b000, swe_rec.typ,
                          8'h00, addr_field,
                          3'b000, fault_q[2], swe_active,
                          fault_q[1], fault_q[0], wp_active};

endmodule

// File: rtl/avm_checker.sv
module avm_checker
    import avm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              wp_enable,
    input logic              start_cmd,
    input logic              seq_fault,
    input logic              clk_glitch,
    input logic              pkey_fault,
    input logic [31:0]       status_word
);

    logic [ADDR_W-3:0] c_idx;
    logic              c_self;
    logic              c_prot;
    logic              c_quiet;
    reg_kind_e         c_kind;

    assign c_idx   = bus_addr[ADDR_W-1:2];
    assign c_kind  = kind_of(32'(c_idx));
    assign c_self  = (32'(c_idx) == STATUS_IDX);
    assign c_prot  = (c_kind == K_CFG) || (c_kind == K_KEY);
    assign c_quiet = !start_cmd && !seq_fault && !clk_glitch && !pkey_fault;

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[30:28] == 3'b0) && (status_word[23:16] == 8'h0) && (status_word[7:5] == 3'b0)); // R1

    AST_WP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && wp_enable && c_prot) |=> status_word[0]); // R2

    AST_WP_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[0] && !(bus_rd && c_self)) |=> (status_word[0] && $stable(status_word[15:8]))); // R3

    AST_TYPE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[27:24] <= 4'd5); // R4

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[31] && !(bus_rd && c_self)) |=> (status_word[31] && $stable(status_word[27:24]))); // R7

    AST_CLASS_NEEDS_SWE: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[31] |-> status_word[3]); // R7

    AST_GLITCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        clk_glitch |=> status_word[1]); // R8

    AST_SEQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        seq_fault |=> status_word[2]); // R8

    AST_PKEY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        pkey_fault |=> status_word[4]); // R8

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && c_self && c_quiet) |=> (status_word == 32'h0)); // R9

    AST_SELF_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && c_self && c_quiet && status_word == 32'h0) |=> (status_word == 32'h0)); // R10

endmodule

bind access_violation_monitor avm_checker #(.ADDR_W(ADDR_W)) u_avm_checker (.*);

// File: tb/test_access_violation_monitor.sv
`timescale 1ns/1ps
module test_access_violation_monitor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic       wp_enable = 1'b0;
    logic       busy = 1'b0;
    logic       key_loaded = 1'b1;
    logic       dma_mode = 1'b0;
    logic       start_cmd = 1'b0;
    logic       seq_fault = 1'b0;
    logic       clk_glitch = 1'b0;
    logic       pkey_fault = 1'b0;
    logic [31:0] status_word;

    int    n_checks = 0;
    int    n_fails = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference model state
    bit m_wp, m_cgd, m_seq, m_pk;
    int m_wpaddr;
    int m_swe;      // 0 none, 1 warning held, 2 error held
    int m_typ, m_cls, m_addr;
    int e_idx, e_typ, e_cls, e_addr;
    bit e_swe, e_wp, e_wo, e_ro, e_prot, e_def, e_start;

    always #5 clk = ~clk;

    access_violation_monitor #(.ADDR_W(8)) i_access_violation_monitor (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .wp_enable(wp_enable), .busy(busy), .key_loaded(key_loaded), .dma_mode(dma_mode),
        .start_cmd(start_cmd), .seq_fault(seq_fault), .clk_glitch(clk_glitch),
        .pkey_fault(pkey_fault), .status_word(status_word)
    );

    function automatic logic [31:0] model_word();
        logic [7:0] f;
        f = m_wp ? 8'(m_wpaddr) : 8'(m_addr);
        return {1'(m_cls), 3'b000, 4'(m_typ), 8'h00, f, 3'b000,
                m_pk, (m_swe != 0), m_seq, m_cgd, m_wp};
    endfunction

    // behavioural reference: clear first, then apply this cycle's events
    always @(posedge clk) begin
        if (!rst_n) begin
            m_wp = 0; m_cgd = 0; m_seq = 0; m_pk = 0; m_wpaddr = 0;
            m_swe = 0; m_typ = 0; m_cls = 0; m_addr = 0;
        end else begin
            e_idx  = int'(bus_addr) / 4;
            e_wo   = (e_idx == 0) || (e_idx >= 4 && e_idx <= 15);
            e_ro   = (e_idx == 2) || (e_idx >= 16 && e_idx <= 19);
            e_prot = (e_idx == 1) || (e_idx >= 4 && e_idx <= 11);
            e_def  = (e_idx <= 2) || (e_idx >= 4 && e_idx <= 19) || (e_idx == 58);
            e_wp   = bus_wr && wp_enable && e_prot;
            e_swe  = 0; e_typ = 0; e_cls = 0; e_addr = e_idx;
            if ((bus_rd || bus_wr) && e_idx != 58 && !e_wp) begin
                if (!e_def)                   begin e_swe = 1; e_typ = 2; end
                else if (bus_rd && e_wo)      begin e_swe = 1; e_typ = 0; end
                else if (bus_wr && e_ro)      begin e_swe = 1; e_typ = 1; end
                else if (busy && bus_wr && e_wo) begin e_swe = 1; e_typ = 4; e_cls = 1; end
                else if (busy && bus_wr && e_idx == 1) begin e_swe = 1; e_typ = 4; end
                else if (busy && bus_rd && e_idx >= 16 && e_idx <= 19) begin e_swe = 1; e_typ = 4; end
            end
            e_start = 0;
            if (start_cmd && dma_mode) begin e_start = 1; e_typ = 3; e_cls = 0; end
            else if (start_cmd && !key_loaded) begin e_start = 1; e_typ = 5; e_cls = 1; end
            if (e_start) begin e_swe = 1; e_addr = 0; end

            if (bus_rd && e_idx == 58) begin
                m_wp = 0; m_cgd = 0; m_seq = 0; m_pk = 0; m_wpaddr = 0;
                m_swe = 0; m_typ = 0; m_cls = 0; m_addr = 0;
            end
            if (e_wp && !m_wp) begin m_wp = 1; m_wpaddr = e_idx; end
            if (e_swe && (m_swe == 0 || (m_swe == 1 && e_cls == 1))) begin
                m_swe = (e_cls == 1) ? 2 : 1;
                m_typ = e_typ; m_cls = e_cls; m_addr = e_addr;
            end
            if (clk_glitch) m_cgd = 1;
            if (seq_fault)  m_seq = 1;
            if (pkey_fault) m_pk = 1;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_checks++;
            if (status_word !== model_word()) begin
                n_fails++;
                $display("FAIL %s: status_word actual %h expected %h", cur_req, status_word, model_word());
            end
        end
    end

    task automatic step(input logic [7:0] a, input bit r, input bit w,
                        input bit st, input bit sq, input bit cg, input bit pk);
        @(negedge clk);
        bus_addr = a; bus_rd = r; bus_wr = w;
        start_cmd = st; seq_fault = sq; clk_glitch = cg; pkey_fault = pk;
        @(negedge clk);
        bus_rd = 0; bus_wr = 0; start_cmd = 0; seq_fault = 0; clk_glitch = 0; pkey_fault = 0;
    endtask

    task automatic rd(input logic [7:0] a); step(a, 1, 0, 0, 0, 0, 0); endtask
    task automatic wr(input logic [7:0] a); step(a, 0, 1, 0, 0, 0, 0); endtask
    task automatic clr_status(); rd(8'hE8); endtask

    task automatic expect_word(input string req, input logic [31:0] exp);
        @(negedge clk);
        n_checks++;
        if (status_word !== exp) begin
            n_fails++;
            $display("FAIL %s: status_word actual %h expected %h", req, status_word, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        n_checks++;
        if (status_word !== 32'h0) begin
            n_fails++;
            $display("FAIL R1: reset actual %h expected 00000000", status_word);
        end
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R2 protected writes
        cur_req = "R2";
        wp_enable = 1;
        wr(8'h04);
        expect_word("R2", 32'h0000_0101);
        clr_status();
        expect_word("R9", 32'h0);
        wr(8'h2C);
        expect_word("R2", 32'h0000_0B01);
        clr_status();

        // R3 protect address keeps priority
        cur_req = "R3";
        wr(8'h14);
        wr(8'h04);
        rd(8'h0C);
        expect_word("R3", 32'h0200_0509);
        clr_status();
        wp_enable = 0;

        // R4 warnings with address capture
        cur_req = "R4";
        rd(8'h10);
        expect_word("R4", 32'h0000_0408);
        clr_status();
        wr(8'h08);
        expect_word("R4", 32'h0100_0208);
        clr_status();
        rd(8'h80);
        expect_word("R4", 32'h0200_2008);
        clr_status();
        wr(8'h40);
        expect_word("R4", 32'h0100_1008);
        clr_status();

        // R5 accesses during processing
        cur_req = "R5";
        busy = 1;
        wr(8'h18);
        expect_word("R5", 32'h8400_0608);
        clr_status();
        wr(8'h04);
        expect_word("R5", 32'h0400_0108);
        clr_status();
        rd(8'h44);
        expect_word("R5", 32'h0400_1108);
        clr_status();
        wr(8'h30);
        expect_word("R5", 32'h8400_0C08);
        clr_status();
        wr(8'h00);
        expect_word("R5", 32'h8400_0008);
        clr_status();
        busy = 0;
        wr(8'h18);
        expect_word("R5", 32'h0);

        // R6 start command misuse
        cur_req = "R6";
        dma_mode = 1;
        step(8'h00, 0, 0, 1, 0, 0, 0);
        expect_word("R6", 32'h0300_0008);
        clr_status();
        key_loaded = 0;
        step(8'h00, 0, 0, 1, 0, 0, 0);
        expect_word("R6", 32'h0300_0008);
        clr_status();
        dma_mode = 0;
        step(8'h00, 0, 0, 1, 0, 0, 0);
        expect_word("R6", 32'h8500_0008);
        clr_status();
        key_loaded = 1;
        step(8'h00, 0, 0, 1, 0, 0, 0);
        expect_word("R6", 32'h0);

        // R7 first record kept, error displaces warning
        cur_req = "R7";
        rd(8'h90);
        rd(8'h34);
        expect_word("R7", 32'h0200_2408);
        busy = 1;
        wr(8'h1C);
        expect_word("R7", 32'h8400_0708);
        busy = 0;
        key_loaded = 0;
        step(8'h00, 0, 0, 1, 0, 0, 0);
        key_loaded = 1;
        expect_word("R7", 32'h8400_0708);
        clr_status();

        // R8 external fault flags
        cur_req = "R8";
        step(8'h00, 0, 0, 0, 0, 1, 0);
        repeat (3) @(negedge clk);
        expect_word("R8", 32'h0000_0002);
        step(8'h00, 0, 0, 0, 1, 0, 1);
        expect_word("R8", 32'h0000_0016);
        clr_status();
        expect_word("R8", 32'h0);

        // R9 event during clearing read wins
        cur_req = "R9";
        rd(8'h84);
        step(8'hE8, 1, 0, 0, 1, 0, 0);
        expect_word("R9", 32'h0000_0004);
        key_loaded = 0;
        step(8'hE8, 1, 0, 1, 0, 0, 0);
        key_loaded = 1;
        expect_word("R9", 32'h8500_0008);
        clr_status();

        // R10 the status word itself
        cur_req = "R10";
        wp_enable = 1;
        busy = 1;
        wr(8'hE8);
        rd(8'hE8);
        expect_word("R10", 32'h0);
        busy = 0;
        wp_enable = 0;

        // mixed random traffic, compared each clock against the model
        cur_req = "R3/R7 mix";
        for (int i = 0; i < 600; i++) begin
            int k;
            logic [7:0] a;
            k = int'($urandom_range(0, 9));
            case (k)
                0: a = 8'h04;
                1: a = 8'h14;
                2: a = 8'h08;
                3: a = 8'h40;
                4: a = 8'h30;
                5: a = 8'hE8;
                6: a = 8'hC4;
                7: a = 8'h00;
                default: a = 8'(($urandom_range(0, 63)) * 4);
            endcase
            @(negedge clk);
            wp_enable  = $urandom_range(0, 1) == 1;
            busy       = $urandom_range(0, 1) == 1;
            key_loaded = $urandom_range(0, 3) != 0;
            dma_mode   = $urandom_range(0, 3) == 0;
            bus_addr   = a;
            k = int'($urandom_range(0, 2));
            bus_rd     = (k == 1);
            bus_wr     = (k == 2);
            start_cmd  = $urandom_range(0, 7) == 0;
            seq_fault  = $urandom_range(0, 15) == 0;
            clk_glitch = $urandom_range(0, 15) == 0;
            pkey_fault = $urandom_range(0, 15) == 0;
        end
        @(negedge clk);
        bus_rd = 0; bus_wr = 0; start_cmd = 0; seq_fault = 0; clk_glitch = 0; pkey_fault = 0;
        repeat (2) @(negedge clk);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule